// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is a target on a two-wire serial bus (SCL clock, SDA data, open-drain) that fronts a byte-wide memory built from registers. A system clock oversamples both bus lines through synchronisers. The block recognises start, repeated-start and stop conditions, checks an address byte against a fixed family code and three strap inputs, and then reads or writes the memory.

Writes carry a two-byte memory address followed by any number of data bytes. Each data byte is stored as soon as its last bit arrives, so the block never reports itself busy. Reads always begin at a persistent address latch. To read from a chosen address, the controller writes the two address bytes and then issues a repeated start with the read bit set. The latch steps by one after every data byte, in both directions, and wraps at the top of memory.

A write-protect input blocks all writes. While it is high, data bytes are not acknowledged, the memory keeps its contents and the latch stays where it is. The memory address width is a parameter, `ADDR_W`, which defaults to 11 bits (2048 bytes). An 8192-byte instance sets it to 13.

Top module: `tw_mem_target`

## Requirements
- R1: The device byte is family code 4'b1010 in bits 7:4, strap value in bits 3:1 and direction in bit 0 (0 = write, 1 = read). The target acknowledges it (SDA low during the 9th SCL high) only when bits 7:4 equal 1010 and bits 3:1 equal `sel_i`. Any other device byte gets no acknowledge and the target goes idle.
- R2: After a write-direction device byte, the target takes and acknowledges two address bytes, high byte first. Bits of the high byte above `ADDR_W`-9 are ignored.
- R3: Every byte is transferred most significant bit first, in both directions.
- R4: With write-protect low, each data byte is stored at the latch address when its 8th bit is received and is acknowledged. The latch then steps by one, so a burst fills consecutive locations.
- R5: The latch wraps from all ones (0x7FF at the default width) to 0, for both writes and reads.
- R6: Reset sets the latch to 0. The latch keeps its value across stop conditions, and a read that is not preceded by an address phase starts at the current latch value.
- R7: During a read, the target drives 8 bits and then samples the controller. An acknowledge (SDA low) continues with the next location. A no-acknowledge ends the read with SDA released.
- R8: A start or stop that arrives before the 8th bit of a data byte discards that partial byte. Memory and latch are left unchanged.
- R9: With `wp_i` high, address bytes are still acknowledged, but data bytes are not. Memory is not written and the latch does not step.
- R10: A device byte sent right after a write transaction is acknowledged. There is no busy period.
- R11: The target changes its SDA drive only while SCL is low, so every bit it sends is steady across the whole SCL high time.
- R12: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Out of reset and when idle, SDA is released (`sda_oe_o` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| sel_i | input | 3 | Strap value that the device byte bits 3:1 must match |
| wp_i | input | 1 | Write protect, high blocks all writes |

## Verification
The hardest case to reach from the pins is a transaction cut short in the middle of a byte. A controller that only exchanges whole bytes never produces a start or stop between the 3rd and 8th bit. The bench therefore drives single bits by hand, places a stop or repeated start after a partial data byte, and then reads back both the memory and the latch position through an ordinary current-address read. The protected write path is reached in the same way: a full protected burst is followed by a current read, which shows the latch did not move and the stored byte did not change.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    // Upper nibble every device byte must carry to select this target.
    localparam logic [3:0] TW_FAMILY = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_RACK
    } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {W{IDLE_LV}};
        else        pipe_q <= pipe_d;
    end

    // pipe_q[W-2] is the synchronised level, pipe_q[W-1] the level one cycle older.
    assign level_o = pipe_q[W-2];
    assign rise_o  =  pipe_q[W-2] & ~pipe_q[W-1];
    assign fall_o  = ~pipe_q[W-2] &  pipe_q[W-1];
endmodule

// File: rtl/tw_byte_store.sv
`timescale 1ns/1ps
module tw_byte_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[addr_i] <= wdata_i;
    end

    assign rdata_o = cells[addr_i];
endmodule

// File: rtl/tw_target_ctrl.sv
`timescale 1ns/1ps
module tw_target_ctrl
    import tw_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          sda_lvl_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    sel_i,
    input  logic          wp_i,
    input  logic [7:0]    rd_data_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    output logic          sda_oe_o
);
    typedef struct packed {
        tw_state_e     st;
        tw_state_e     nxt;     // state taken after the acknowledge slot
        logic [6:0]    sh;      // shift register (7 bits; the 8th is the live line or the output)
        logic [3:0]    cnt;     // SCL edges counted in the current byte
        logic          ack_ok;  // acknowledge decision for the pending slot
        logic          oe;
        logic          mack;    // controller acknowledged the last read byte
        logic [AW-9:0] hi;      // kept bits of the high address byte
        logic [AW-1:0] latch;   // persistent address latch
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [7:0]    byte_in;
    logic          hit;
    logic [AW-1:0] ld_addr;
    logic          we;

    always_comb begin
        ctl_d   = ctl_q;
        we      = 1'b0;
        byte_in = {ctl_q.sh, sda_lvl_i};
        hit     = (byte_in[7:4] == TW_FAMILY) && (byte_in[3:1] == sel_i);
        ld_addr = {ctl_q.hi, byte_in};

        if (start_i) begin
            ctl_d.st  = ST_DEV;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else if (stop_i) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
                    if (scl_rise_i) begin
                        ctl_d.sh  = byte_in[6:0];
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                        if (ctl_q.cnt == 4'd7) begin
                            if (ctl_q.st == ST_DEV) begin
                                ctl_d.ack_ok = hit;
                                ctl_d.nxt    = !hit ? ST_IDLE : (byte_in[0] ? ST_RD : ST_AHI);
                            end else if (ctl_q.st == ST_AHI) begin
                                ctl_d.hi     = byte_in[AW-9:0];
                                ctl_d.ack_ok = 1'b1;
                                ctl_d.nxt    = ST_ALO;
                            end else if (ctl_q.st == ST_ALO) begin
                                ctl_d.latch  = ld_addr;
                                ctl_d.ack_ok = 1'b1;
                                ctl_d.nxt    = ST_WR;
                            end else begin
                                if (!wp_i) begin
                                    we          = 1'b1;
                                    ctl_d.latch = ctl_q.latch + AW'(1);
                                end
                                ctl_d.ack_ok = !wp_i;
                                ctl_d.nxt    = ST_WR;
                            end
                        end
                    end
                    if (scl_fall_i && ctl_q.cnt == 4'd8) begin
                        ctl_d.st  = ST_ACK;
                        ctl_d.oe  = ctl_q.ack_ok;
                        ctl_d.cnt = '0;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        ctl_d.st  = ctl_q.nxt;
                        ctl_d.cnt = '0;
                        ctl_d.oe  = 1'b0;
                        if (ctl_q.nxt == ST_RD) begin
                            ctl_d.sh = rd_data_i[6:0];
                            ctl_d.oe = ~rd_data_i[7];
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise_i) begin
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                        if (ctl_q.cnt == 4'd7) ctl_d.latch = ctl_q.latch + AW'(1);
                    end
                    if (scl_fall_i) begin
                        if (ctl_q.cnt == 4'd8) begin
                            ctl_d.oe   = 1'b0;
                            ctl_d.st   = ST_RACK;
                            ctl_d.mack = 1'b0;
                        end else begin
                            ctl_d.sh = {ctl_q.sh[5:0], 1'b0};
                            ctl_d.oe = ~ctl_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) ctl_d.mack = ~sda_lvl_i;
                    if (scl_fall_i) begin
                        if (ctl_q.mack) begin
                            ctl_d.st  = ST_RD;
                            ctl_d.cnt = '0;
                            ctl_d.sh  = rd_data_i[6:0];
                            ctl_d.oe  = ~rd_data_i[7];
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_IDLE;
            ctl_q.nxt    <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_we_o    = we;
    assign mem_addr_o  = ctl_q.latch;
    assign mem_wdata_o = byte_in;
    assign sda_oe_o    = ctl_q.oe;

    // R11: drive level never moves while SCL stays high
    a_r11_drive_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl_i && $past(scl_lvl_i)) |-> $stable(ctl_q.oe));

    // R12: an idle target leaves SDA released
    a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !ctl_q.oe);

    // R7: SDA is released while the controller answers a read byte
    a_r7_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RACK) |-> !ctl_q.oe);

    // R4 / R5: outside an address load the latch only moves by +1 modulo its width
    a_r4_latch_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.latch != $past(ctl_q.latch)) && ($past(ctl_q.st) != ST_ALO))
        |-> (ctl_q.latch == $past(ctl_q.latch) + AW'(1)));

    // R9: a protected write phase never moves the latch
    a_r9_wp_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WR && $past(ctl_q.st) == ST_WR && $past(wp_i))
        |-> (ctl_q.latch == $past(ctl_q.latch)));
endmodule

// File: rtl/tw_mem_target.sv
`timescale 1ns/1ps
module tw_mem_target #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] sel_i,
    input  logic       wp_i
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_p, stop_p;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    tw_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    tw_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    // SCL must be high now and one cycle ago for a data-line edge to be a condition.
    assign start_p = sda_fall & scl_lvl & ~scl_rise;
    assign stop_p  = sda_rise & scl_lvl & ~scl_rise;

    tw_target_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .sda_lvl_i(sda_lvl), .start_i(start_p), .stop_i(stop_p),
        .sel_i(sel_i), .wp_i(wp_i), .rd_data_i(mem_rdata),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .sda_oe_o(sda_oe_o)
    );

    tw_byte_store #(.AW(ADDR_W), .DW(8)) u_store (
        .clk(clk), .we_i(mem_we), .addr_i(mem_addr),
        .wdata_i(mem_wdata), .rdata_o(mem_rdata)
    );
endmodule

// File: tb/tw_mem_target_bench.sv
`timescale 1ns/1ps
module tw_mem_target_bench;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int MASK  = DEPTH - 1;
    localparam int TQ    = 100;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'hA, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'hA, STRAP, 1'b1};

    // {address high byte, address low byte, data}
    localparam logic [23:0] VEC [8] = '{
        24'h00_05_A5, 24'hF8_00_5A, 24'h07_FE_01, 24'h03_33_80,
        24'hA4_44_7E, 24'h01_00_FF, 24'h02_AB_00, 24'h5D_10_C3
    };

    logic clk = 1'b0;
    logic rst_n, scl, m_low, wp, sda_oe;
    logic [2:0] sel;
    logic sda_bus;
    int nvec = 0, nfail = 0;
    logic [7:0] model [DEPTH];

    assign sda_bus = !(m_low | sda_oe);

    always #5 clk = ~clk;

    tw_mem_target #(.ADDR_W(AW)) u_tw_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .sel_i(sel), .wp_i(wp)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; #TQ; scl = 1'b1; #TQ; m_low = 1'b1; #TQ; scl = 1'b0; #TQ;
    endtask

    task automatic bus_stop();
        m_low = 1'b1; #TQ; scl = 1'b1; #TQ; m_low = 1'b0; #(2*TQ);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; #TQ; scl = 1'b1; #(2*TQ); scl = 1'b0; #TQ;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; #TQ; scl = 1'b1; #TQ; ack = !sda_bus; #TQ; scl = 1'b0; #TQ;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic steady);
        steady = 1'b1;
        m_low  = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            #TQ; scl = 1'b1; #TQ; b[i] = sda_bus;
            #(TQ/2); if (sda_bus !== b[i]) steady = 1'b0;
            #(TQ/2); scl = 1'b0;
        end
        m_low = give_ack; #TQ; scl = 1'b1; #(2*TQ); scl = 1'b0; #TQ; m_low = 1'b0;
    endtask

    task automatic addr_phase(input logic [15:0] a, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte(DEV_W, k1);
        send_byte(a[15:8], k2);
        send_byte(a[7:0], k3);
        ok = k1 & k2 & k3;
    endtask

    task automatic rd_cur(output logic [7:0] d);
        logic k, st;
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d, st);
        bus_stop();
    endtask

    initial begin
        logic ok, ack, st;
        logic [7:0] d;
        logic [15:0] a;
        rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; wp = 1'b0; sel = STRAP;
        #100; rst_n = 1'b1; #100;
        chk("R12 idle SDA released after reset", int'(sda_oe), 0);

        // R6: latch reset to 0, memory survives reset
        addr_phase(16'h0000, ok); send_byte(8'h5A, ack); bus_stop();
        model[0] = 8'h5A;
        rst_n = 1'b0; #100; rst_n = 1'b1; #100;
        rd_cur(d);
        chk("R6 reset latch", int'(d), 'h5A);

        // Table: single write + random read per vector (R2, R3, R4)
        for (int v = 0; v < 8; v++) begin
            a = VEC[v][23:8];
            addr_phase(a, ok);
            chk("R2 address bytes acked", int'(ok), 1);
            send_byte(VEC[v][7:0], ack);
            chk("R4 data acked", int'(ack), 1);
            bus_stop();
            model[int'(a) & MASK] = VEC[v][7:0];
            addr_phase(a, ok);
            bus_start(); send_byte(DEV_R, ack);
            recv_byte(1'b0, d, st);
            bus_stop();
            chk("R3 R2 readback", int'(d), int'(model[int'(a) & MASK]));
        end

        // R1: wrong strap and wrong family code
        bus_start(); send_byte({4'hA, 3'b011, 1'b0}, ack);
        chk("R1 wrong strap", int'(ack), 0); bus_stop();
        bus_start(); send_byte({4'hB, STRAP, 1'b0}, ack);
        chk("R1 wrong family", int'(ack), 0); bus_stop();
        bus_start(); send_byte(DEV_W, ack);
        chk("R1 matching device", int'(ack), 1); bus_stop();

        // R4: burst of five bytes at 0x100
        addr_phase(16'h0100, ok);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'(8'h11 * (i + 1)), ack);
            model[16'h100 + i] = 8'(8'h11 * (i + 1));
            chk("R4 burst byte acked", int'(ack), 1);
        end
        bus_stop();
        // R10: immediate poll
        bus_start(); send_byte(DEV_W, ack);
        chk("R10 no busy after write", int'(ack), 1); bus_stop();

        // R7 / R11: sequential read of four, NACK on last
        addr_phase(16'h0100, ok);
        bus_start(); send_byte(DEV_R, ack);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i < 3, d, st);
            chk("R7 sequential read", int'(d), int'(model[16'h100 + i]));
            chk("R11 bit steady over SCL high", int'(st), 1);
        end
        chk("R7 SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        // R6: latch persists across stop
        rd_cur(d);
        chk("R6 current read after stop", int'(d), int'(model[16'h104]));

        // R5: wrap
        addr_phase(16'(MASK), ok);
        send_byte(8'h9A, ack); send_byte(8'hBC, ack); bus_stop();
        model[MASK] = 8'h9A; model[0] = 8'hBC;
        addr_phase(16'(MASK), ok);
        bus_start(); send_byte(DEV_R, ack);
        recv_byte(1'b1, d, st); chk("R5 top byte", int'(d), 'h9A);
        recv_byte(1'b0, d, st); chk("R5 wrapped byte", int'(d), 'hBC);
        bus_stop();

        // R9: write protect
        addr_phase(16'h0200, ok); send_byte(8'h66, ack); bus_stop();
        model[16'h200] = 8'h66;
        wp = 1'b1;
        addr_phase(16'h0200, ok);
        chk("R9 address acked under protect", int'(ok), 1);
        send_byte(8'h99, ack); chk("R9 data not acked", int'(ack), 0);
        send_byte(8'h77, ack); chk("R9 second data not acked", int'(ack), 0);
        bus_stop();
        wp = 1'b0;
        rd_cur(d);
        chk("R9 memory and latch unchanged", int'(d), 'h66);

        // R8: partial byte cut by stop, then by repeated start
        addr_phase(16'h0300, ok); send_byte(8'h12, ack); bus_stop();
        model[16'h300] = 8'h12;
        addr_phase(16'h0300, ok);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop();
        rd_cur(d);
        chk("R8 stop discards partial byte", int'(d), 'h12);
        addr_phase(16'h0300, ok);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start(); send_byte(DEV_R, ack);
        recv_byte(1'b0, d, st);
        bus_stop();
        chk("R8 start discards partial byte", int'(d), 'h12);
        chk("R12 released after final stop", int'(sda_oe), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #1900000;
        nfail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule